// File: doc/BRIEF.md
# Node-ID Port Router

This block is the steering stage of a four-port switching hub that links nodes into rings. Port 0 faces the local host side; ports 1 and 2 are the two directions of the local ring, ascending and descending node IDs; port 3 is the cross link to a second ring. Every packet is a header beat followed by zero or more payload beats. Each beat moves with a valid/ready handshake and a last flag. The header beat carries a write address, and the destination node ID sits in address bits that the host address space never uses.

No table is consulted. A few magnitude comparators set the destination against the node's own ID, the bounds of the local ring and the number of nodes in the system, and from that result the block picks the output. A packet for the local node has its node-ID bits zeroed before it reaches the host port. A packet for a node that does not exist is consumed and counted, and it goes nowhere. Each output has its own round-robin arbiter that holds its grant for a whole packet, so packets that share an output are never mixed.

Top module: `nid_port_router`

## Requirements
- R1: A header whose node field (bits [ADDR_W-1:ADDR_W-NODE_W] of the beat, [47:44] by default) equals `cfg_local_id` leaves on port 0 with that field cleared. Every other bit of the beat is unchanged.
- R2: For a destination within [`cfg_ring_lo`, `cfg_ring_hi`] other than the local ID, the packet leaves on port 1 when the destination is above the local ID and on port 2 when it is below.
- R3: A destination below `cfg_node_count` but outside the ring bounds leaves on port 3.
- R4: A destination at or above `cfg_node_count` has all its beats accepted and none forwarded. `drop_count` rises by one for each such packet, saturates, and never decreases.
- R5: Payload beats follow their header's output port unaltered until the beat flagged last. Every forwarded beat arrives in the order it was sent from its input.
- R6: Once an output has started a packet from one input, it carries beats only from that input until that packet's last beat.
- R7: Inputs that contend for one output are served a whole packet each in rotating order. After reset the rotation starts after input 0, so input 1 wins a first contest between inputs 1 and 2.
- R8: An output that is valid while its ready is low keeps valid, data and last unchanged into the next cycle. An input that wants an output granted to another input sees its ready low.
- R9: During reset and after it with idle inputs, all outputs are invalid and `drop_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_local_id | input | NODE_W | This node's ID |
| cfg_ring_lo | input | NODE_W | Lowest node ID on the local ring |
| cfg_ring_hi | input | NODE_W | Highest node ID on the local ring |
| cfg_node_count | input | NODE_W+1 | Number of nodes in the system |
| in_valid | input | PORTS | Beat valid per input |
| in_ready | output | PORTS | Beat accepted per input |
| in_last | input | PORTS | Last beat of packet per input |
| in_data | input | PORTS x DATA_W | Beat data per input |
| out_valid | output | PORTS | Beat valid per output |
| out_ready | input | PORTS | Downstream ready per output |
| out_last | output | PORTS | Last beat of packet per output |
| out_data | output | PORTS x DATA_W | Beat data per output |
| drop_count | output | CNT_W | Saturating count of discarded packets |

## Verification
The hardest case to reach from the ports is a losing input that waits on an output held by another input's multi-beat packet, while that output is itself stalled mid-packet. The stimulus gets there by running multi-beat packets on all four inputs at once, with destinations chosen so that several inputs share each output, while a shift-register pattern pulls output ready low on about a quarter of cycles. A separate directed contest between two inputs sending back-to-back packets to the host port pins down the rotation order of the arbiter.

// File: rtl/nrt_pkg.sv
package nrt_pkg;

    localparam int unsigned PORTS  = 4;
    localparam int unsigned PORT_W = 2;

    // Output roles: host side, ring toward higher IDs, ring toward lower IDs, cross link.
    typedef enum logic [PORT_W-1:0] {
        PORT_HOST  = 2'd0,
        PORT_UP    = 2'd1,
        PORT_DOWN  = 2'd2,
        PORT_CROSS = 2'd3
    } port_e;

    typedef struct packed {
        logic  drop;
        port_e port;
    } route_t;

    // Comparator-only routing decision. Node IDs arrive zero-extended to 8 bits.
    function automatic route_t pick_route(
        input logic [7:0] dst,
        input logic [7:0] self_id,
        input logic [7:0] ring_lo,
        input logic [7:0] ring_hi,
        input logic [8:0] node_count
    );
        route_t r;
        r.drop = 1'b0;
        r.port = PORT_HOST;
        if ({1'b0, dst} >= node_count) begin
            r.drop = 1'b1;
        end else if (dst == self_id) begin
            r.port = PORT_HOST;
        end else if (dst >= ring_lo && dst <= ring_hi) begin
            r.port = (dst > self_id) ? PORT_UP : PORT_DOWN;
        end else begin
            r.port = PORT_CROSS;
        end
        return r;
    endfunction

endpackage

// File: rtl/nrt_steer.sv
module nrt_steer
    import nrt_pkg::*;
#(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned NODE_W   = 4,
    parameter int unsigned NODE_LSB = 44
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NODE_W-1:0]   cfg_local_id,
    input  logic [NODE_W-1:0]   cfg_ring_lo,
    input  logic [NODE_W-1:0]   cfg_ring_hi,
    input  logic [NODE_W:0]     cfg_node_count,
    input  logic                in_valid,
    input  logic                in_last,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [PORTS-1:0]    port_ready,
    output logic                in_ready,
    output logic [PORTS-1:0]    req,
    output logic [DATA_W-1:0]   fwd_data,
    output logic                drop_hit
);

    logic   mid_q;
    logic   drop_q;
    port_e  port_q;
    route_t hdr_route;
    logic   cur_drop;
    port_e  cur_port;
    logic   accept;

    always_comb begin
        hdr_route = pick_route(8'(in_data[NODE_LSB +: NODE_W]), 8'(cfg_local_id),
                               8'(cfg_ring_lo), 8'(cfg_ring_hi), 9'(cfg_node_count));
        // The header decides; later beats reuse the stored decision.
        cur_drop = mid_q ? drop_q : hdr_route.drop;
        cur_port = mid_q ? port_q : hdr_route.port;

        req = '0;
        if (in_valid && !cur_drop) begin
            req[cur_port] = 1'b1;
        end
        in_ready = cur_drop ? 1'b1 : port_ready[cur_port];

        fwd_data = in_data;
        if (!mid_q && cur_port == PORT_HOST) begin
            fwd_data[NODE_LSB +: NODE_W] = '0;
        end

        accept   = in_valid && in_ready;
        drop_hit = accept && !mid_q && hdr_route.drop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_q  <= 1'b0;
            drop_q <= 1'b0;
            port_q <= PORT_HOST;
        end else if (accept) begin
            mid_q  <= !in_last;
            drop_q <= cur_drop;
            port_q <= cur_port;
        end
    end

endmodule

// File: rtl/nrt_pkt_arb.sv
module nrt_pkt_arb #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic [N-1:0] last_in,
    input  logic         out_ready,
    output logic [N-1:0] grant,
    output logic         out_valid,
    output logic         out_last
);

    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    logic          locked_q;
    logic [N-1:0]  held_q;
    logic [IW-1:0] ptr_q;
    logic [N-1:0]  pick;
    logic [IW-1:0] idx;
    logic [IW-1:0] gidx;
    logic          found;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        idx   = '0;
        // Search starts one past the input served last.
        for (int k = 1; k <= int'(N); k++) begin
            idx = IW'((int'(ptr_q) + k) % int'(N));
            if (!found && req[idx]) begin
                pick[idx] = 1'b1;
                found     = 1'b1;
            end
        end
        grant     = locked_q ? held_q : pick;
        out_valid = |(grant & req);
        out_last  = |(grant & req & last_in);
        gidx = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (grant[i]) gidx = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
            held_q   <= '0;
            ptr_q    <= '0;
        end else if (out_valid) begin
            if (out_ready && out_last) begin
                locked_q <= 1'b0;
                ptr_q    <= gidx;
            end else begin
                locked_q <= 1'b1;
                held_q   <= grant;
            end
        end
    end

endmodule

// File: rtl/nid_port_router.sv
module nid_port_router
    import nrt_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ADDR_W = 48,
    parameter int unsigned NODE_W = 4,
    parameter int unsigned CNT_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NODE_W-1:0]              cfg_local_id,
    input  logic [NODE_W-1:0]              cfg_ring_lo,
    input  logic [NODE_W-1:0]              cfg_ring_hi,
    input  logic [NODE_W:0]                cfg_node_count,
    input  logic [PORTS-1:0]               in_valid,
    output logic [PORTS-1:0]               in_ready,
    input  logic [PORTS-1:0]               in_last,
    input  logic [PORTS-1:0][DATA_W-1:0]   in_data,
    output logic [PORTS-1:0]               out_valid,
    input  logic [PORTS-1:0]               out_ready,
    output logic [PORTS-1:0]               out_last,
    output logic [PORTS-1:0][DATA_W-1:0]   out_data,
    output logic [CNT_W-1:0]               drop_count
);

    localparam int unsigned NODE_LSB = ADDR_W - NODE_W;

    logic [PORTS-1:0][PORTS-1:0]  steer_req;  // [input][output]
    logic [PORTS-1:0][PORTS-1:0]  req_col;    // [output][input]
    logic [PORTS-1:0][PORTS-1:0]  arb_grant;  // [output][input]
    logic [PORTS-1:0][PORTS-1:0]  port_rdy;   // [input][output]
    logic [PORTS-1:0][DATA_W-1:0] fwd;
    logic [PORTS-1:0]             drop_hit;
    logic [CNT_W:0]               cnt_sum;

    always_comb begin
        for (int o = 0; o < int'(PORTS); o++) begin
            for (int i = 0; i < int'(PORTS); i++) begin
                req_col[o][i]  = steer_req[i][o];
                port_rdy[i][o] = out_ready[o] & arb_grant[o][i];
            end
        end
    end

    for (genvar i = 0; i < PORTS; i++) begin : g_in
        nrt_steer #(
            .DATA_W  (DATA_W),
            .NODE_W  (NODE_W),
            .NODE_LSB(NODE_LSB)
        ) steer_i (
            .clk           (clk),
            .rst           (rst),
            .cfg_local_id  (cfg_local_id),
            .cfg_ring_lo   (cfg_ring_lo),
            .cfg_ring_hi   (cfg_ring_hi),
            .cfg_node_count(cfg_node_count),
            .in_valid      (in_valid[i]),
            .in_last       (in_last[i]),
            .in_data       (in_data[i]),
            .port_ready    (port_rdy[i]),
            .in_ready      (in_ready[i]),
            .req           (steer_req[i]),
            .fwd_data      (fwd[i]),
            .drop_hit      (drop_hit[i])
        );
    end

    for (genvar o = 0; o < PORTS; o++) begin : g_out
        nrt_pkt_arb #(
            .N(PORTS)
        ) arb_i (
            .clk      (clk),
            .rst      (rst),
            .req      (req_col[o]),
            .last_in  (in_last),
            .out_ready(out_ready[o]),
            .grant    (arb_grant[o]),
            .out_valid(out_valid[o]),
            .out_last (out_last[o])
        );

        always_comb begin
            out_data[o] = '0;
            for (int i = 0; i < int'(PORTS); i++) begin
                out_data[o] = out_data[o] | ({DATA_W{arb_grant[o][i]}} & fwd[i]);
            end
        end
    end

    always_comb begin
        cnt_sum = {1'b0, drop_count} + (CNT_W+1)'($countones(drop_hit));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drop_count <= '0;
        end else if (cnt_sum[CNT_W]) begin
            drop_count <= '1;
        end else begin
            drop_count <= cnt_sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/nid_port_router_chk.sv
module nid_port_router_chk
    import nrt_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ADDR_W = 48,
    parameter int unsigned NODE_W = 4,
    parameter int unsigned CNT_W  = 8
) (
    input logic                           clk,
    input logic                           rst,
    input logic [NODE_W-1:0]              cfg_local_id,
    input logic [NODE_W-1:0]              cfg_ring_lo,
    input logic [NODE_W-1:0]              cfg_ring_hi,
    input logic [NODE_W:0]                cfg_node_count,
    input logic [PORTS-1:0]               out_valid,
    input logic [PORTS-1:0]               out_ready,
    input logic [PORTS-1:0]               out_last,
    input logic [PORTS-1:0][DATA_W-1:0]   out_data,
    input logic [CNT_W-1:0]               drop_count,
    input logic [PORTS-1:0][PORTS-1:0]    grant
);

    localparam int unsigned NODE_LSB = ADDR_W - NODE_W;

    logic [PORTS-1:0]             mid;
    logic [PORTS-1:0][NODE_W-1:0] hnode;

    always_comb begin
        for (int o = 0; o < int'(PORTS); o++) begin
            hnode[o] = out_data[o][NODE_LSB +: NODE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mid <= '0;
        end else begin
            for (int o = 0; o < int'(PORTS); o++) begin
                if (out_valid[o] && out_ready[o]) mid[o] <= !out_last[o];
            end
        end
    end

    for (genvar o = 0; o < PORTS; o++) begin : g_prop
        p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
            (out_valid[o] && !out_ready[o]) |=>
            (out_valid[o] && $stable(out_data[o]) && $stable(out_last[o])));

        p_grant_single_r6: assert property (@(posedge clk) disable iff (rst)
            $onehot0(grant[o]));

        p_pkt_whole_r6: assert property (@(posedge clk) disable iff (rst)
            (out_valid[o] && !(out_ready[o] && out_last[o])) |=> $stable(grant[o]));
    end

    p_host_clear_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid[0] && !mid[0]) |-> (hnode[0] == '0));

    p_up_span_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid[1] && !mid[1]) |-> (hnode[1] > cfg_local_id && hnode[1] <= cfg_ring_hi));

    p_down_span_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid[2] && !mid[2]) |-> (hnode[2] < cfg_local_id && hnode[2] >= cfg_ring_lo));

    p_cross_span_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid[3] && !mid[3]) |->
        ((hnode[3] < cfg_ring_lo || hnode[3] > cfg_ring_hi) && ({1'b0, hnode[3]} < cfg_node_count)));

    p_drop_mono_r4: assert property (@(posedge clk) disable iff (rst)
        drop_count >= $past(drop_count));

endmodule

bind nid_port_router nid_port_router_chk #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .NODE_W(NODE_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .cfg_local_id  (cfg_local_id),
    .cfg_ring_lo   (cfg_ring_lo),
    .cfg_ring_hi   (cfg_ring_hi),
    .cfg_node_count(cfg_node_count),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_last      (out_last),
    .out_data      (out_data),
    .drop_count    (drop_count),
    .grant         (arb_grant)
);

// File: tb/nid_port_router_tb_top.sv
module nid_port_router_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;
    localparam int AW = 48;
    localparam int NW = 4;
    localparam int CW = 8;
    localparam int NP = 4;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NW-1:0] cfg_local_id = 4'd5;
    logic [NW-1:0] cfg_ring_lo  = 4'd0;
    logic [NW-1:0] cfg_ring_hi  = 4'd7;
    logic [NW:0]   cfg_node_count = 5'd12;

    logic [NP-1:0]         in_valid = '0;
    logic [NP-1:0]         in_ready;
    logic [NP-1:0]         in_last = '0;
    logic [NP-1:0][DW-1:0] in_data = '0;
    logic [NP-1:0]         out_valid;
    logic [NP-1:0]         out_ready = '1;
    logic [NP-1:0]         out_last;
    logic [NP-1:0][DW-1:0] out_data;
    logic [CW-1:0]         drop_count;

    nid_port_router #(
        .DATA_W(DW), .ADDR_W(AW), .NODE_W(NW), .CNT_W(CW)
    ) dut_i (
        .clk(clk), .rst(rst),
        .cfg_local_id(cfg_local_id), .cfg_ring_lo(cfg_ring_lo),
        .cfg_ring_hi(cfg_ring_hi), .cfg_node_count(cfg_node_count),
        .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last), .out_data(out_data),
        .drop_count(drop_count)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int exp_drops = 0;
    logic [DW:0] exp_q [NP][NP][$];
    int host_order[$];
    int exp_port [NP];
    bit bp_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit mon_stall [NP];
    logic [DW:0] mon_prev [NP];
    bit mon_mid [NP];
    int mon_src [NP];

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [DW:0] act, input logic [DW:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Behavioural routing expectation: 0..3 output, 4 means discarded.
    function automatic int ref_port(input int d);
        int self_id = int'(cfg_local_id);
        if (d >= int'(cfg_node_count)) return 4;
        if (d == self_id) return 0;
        if (d >= int'(cfg_ring_lo) && d <= int'(cfg_ring_hi)) return (d > self_id) ? 1 : 2;
        return 3;
    endfunction

    task automatic send_pkt(input int p, input int dst, input int len, input int tag);
        logic [DW-1:0] beats[$];
        logic [DW-1:0] e;
        int rp;
        rp = ref_port(dst);
        for (int b = 0; b < len; b++) begin
            if (b == 0) beats.push_back({4'(p), 12'(tag), 4'(dst), 44'(tag * 4096 + 'h0abc)});
            else        beats.push_back({4'(p), 60'(tag * 256 + b)});
            e = beats[b];
            if (b == 0 && rp == 0) e[AW-1 -: NW] = '0;
            if (rp != 4) exp_q[p][rp].push_back({(b == len - 1), e});
        end
        if (rp == 4) exp_drops++;
        for (int b = 0; b < len; b++) begin
            @(negedge clk);
            if (b == 0) exp_port[p] = rp;
            in_valid[p] = 1'b1;
            in_data[p]  = beats[b];
            in_last[p]  = (b == len - 1);
            #1;
            while (!in_ready[p]) begin
                @(negedge clk);
                #1;
            end
        end
    endtask

    task automatic idle(input int p);
        @(negedge clk);
        in_valid[p]  = 1'b0;
        in_last[p]   = 1'b0;
        exp_port[p]  = -1;
    endtask

    task automatic traffic(input int p);
        for (int k = 0; k < 12; k++) begin
            send_pkt(p, (p * 7 + k * 5 + 3) % 16, 1 + ((p + k) % 4), 64 + p * 16 + k);
        end
        idle(p);
    endtask

    // Output ready pattern, changed away from the active edge.
    initial begin : bp_drv
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = bp_mode ? (lfsr[3:0] | lfsr[7:4]) : '1;
        end
    end

    // Reference comparison every clock.
    initial begin : monitor
        for (int o = 0; o < NP; o++) begin
            mon_stall[o] = 1'b0; mon_mid[o] = 1'b0; mon_src[o] = -1; exp_port[o] = -1;
        end
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin
                for (int o = 0; o < NP; o++) begin
                    if (mon_stall[o])
                        check(out_valid[o] && ({out_last[o], out_data[o]} == mon_prev[o]),
                              "R8", $sformatf("stalled output %0d changed", o),
                              {out_last[o], out_data[o]}, mon_prev[o]);
                    if (out_valid[o] && out_ready[o]) begin
                        int src;
                        string rq;
                        src = int'(out_data[o][DW-1 -: 4]);
                        rq = mon_mid[o] ? "R5" : (o == 0 ? "R1" : (o == 3 ? "R3" : "R2"));
                        if (mon_mid[o])
                            check(src == mon_src[o], "R6", $sformatf("interleave on output %0d", o),
                                  src, mon_src[o]);
                        if (src >= NP || exp_q[src][o].size() == 0) begin
                            check(1'b0, rq, $sformatf("unexpected beat on output %0d", o),
                                  {out_last[o], out_data[o]}, '0);
                        end else begin
                            logic [DW:0] e;
                            e = exp_q[src][o].pop_front();
                            check({out_last[o], out_data[o]} == e, rq,
                                  $sformatf("beat on output %0d from input %0d", o, src),
                                  {out_last[o], out_data[o]}, e);
                        end
                        if (!mon_mid[o] && o == 0) host_order.push_back(src);
                        mon_mid[o] = !out_last[o];
                        mon_src[o] = src;
                    end
                    mon_stall[o] = out_valid[o] && !out_ready[o];
                    mon_prev[o]  = {out_last[o], out_data[o]};
                end
                for (int i = 0; i < NP; i++) begin
                    int tp;
                    tp = exp_port[i];
                    if (in_valid[i] && tp >= 0 && tp < NP && out_valid[tp] &&
                        int'(out_data[tp][DW-1 -: 4]) != i)
                        check(!in_ready[i], "R8", $sformatf("losing input %0d ready", i),
                              in_ready[i], 0);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (R5): actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int exp_order[6];
        exp_order = '{1, 2, 1, 2, 1, 2};

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        check(out_valid == '0, "R9", "out_valid in reset", out_valid, 0);
        check(drop_count == '0, "R9", "drop_count in reset", drop_count, 0);
        rst = 1'b0;
        @(negedge clk); #2;
        check(out_valid == '0, "R9", "out_valid idle after reset", out_valid, 0);
        check(drop_count == '0, "R9", "drop_count after reset", drop_count, 0);

        // R7: two inputs contend for the host port
        fork
            begin
                for (int k = 0; k < 3; k++) send_pkt(1, 5, 3, 1 + k);
                idle(1);
            end
            begin
                for (int k = 0; k < 3; k++) send_pkt(2, 5, 3, 17 + k);
                idle(2);
            end
        join
        repeat (4) @(negedge clk);
        check(host_order.size() == 6, "R7", "host packet count", host_order.size(), 6);
        for (int j = 0; j < 6; j++) begin
            if (j < host_order.size())
                check(host_order[j] == exp_order[j], "R7", $sformatf("grant order slot %0d", j),
                      host_order[j], exp_order[j]);
        end

        // R1..R4: one packet of each class
        send_pkt(0, 6, 1, 200);   // R2 up
        send_pkt(0, 7, 2, 201);   // R2 up
        send_pkt(0, 4, 1, 202);   // R2 down
        send_pkt(0, 0, 3, 203);   // R2 down
        send_pkt(0, 8, 1, 204);   // R3 cross
        send_pkt(0, 11, 2, 205);  // R3 cross
        send_pkt(0, 5, 2, 206);   // R1 host
        send_pkt(0, 12, 3, 207);  // R4 drop
        send_pkt(0, 15, 1, 208);  // R4 drop
        idle(0);
        send_pkt(3, 5, 2, 209);   // R1 from a link input
        idle(3);
        repeat (4) @(negedge clk);
        #2;
        check(drop_count == CW'(exp_drops), "R4", "drop_count after directed", drop_count, exp_drops);

        // Mixed traffic with backpressure on all inputs
        bp_mode = 1'b1;
        fork
            traffic(0);
            traffic(1);
            traffic(2);
            traffic(3);
        join
        bp_mode = 1'b0;
        repeat (20) @(negedge clk);
        #2;
        check(drop_count == CW'(exp_drops), "R4", "drop_count after mixed", drop_count, exp_drops);
        for (int s = 0; s < NP; s++) begin
            for (int o = 0; o < NP; o++) begin
                check(exp_q[s][o].size() == 0, "R5",
                      $sformatf("beats missing input %0d output %0d", s, o),
                      exp_q[s][o].size(), 0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule